// File: doc/BRIEF.md
# Interrupt Group Modifier Register Bank

This block stores a group-modifier bit and a group-status bit for each of 64 interrupts in an extended ID range (IDs 1056 to 1119). Software reaches both bit sets through a 32-bit register port with a combinational read path. Each access carries a secure/non-secure attribute. The block applies three access rules:
- a security gate, driven by a disable-security input;
- an affinity-routing flag, which reduces the modifier bits to read-as-zero;
- a mask of implemented interrupts.

For every interrupt, the block merges the effective modifier bit and status bit into a 2-bit group class. The distributor logic next to the block uses these class outputs directly.

There are two banks of bit registers, each holding 32 bits per register:
- **Modifier bank:** register index n sits at byte offset 0xD00 + 4n.
- **Status bank:** register index n sits at 0xC80 + 4n.

In both banks, n is 1 or 2. Interrupt m maps to register n = (m-1024) div 32 and to bit (m-1024) mod 32.

Top module: `irq_grpmod_bank`

## Requirements
- R1: Modifier register n (n = 1, 2) responds at byte offset 0xD00 + 4n (0xD04, 0xD08). Its bit b belongs to interrupt 1024 + 32n + b. The class of interrupt m appears on grp_o[2k+1:2k], where k = m - 1056.
- R2: Status register n (n = 1, 2) responds at 0xC80 + 4n (0xC84, 0xC88), with the same bit-to-interrupt mapping as R1.
- R3: The class code is taken from {modifier, status}:
  - 00 gives 2'b00 (Secure Group 0).
  - 01 gives 2'b01 (Non-secure Group 1).
  - 10 gives 2'b10 (Secure Group 1).
- R4: The reserved pair {1,1} is reported as 2'b01 (Non-secure Group 1). The code 2'b11 never appears on grp_o.
- R5: When sec_disable_i is 0, a non-secure access to either bank reads as zero, and its write changes no stored bit.
- R6: When sec_disable_i is 1, or when the access is secure, both banks are readable and writable.
- R7: Bits of interrupts whose impl_mask_i bit is 0 read as zero, ignore writes, and count as 0 in the class decode. Stored bits that are masked off keep their value.
- R8: When route_en_i is 0, modifier bits read as zero, ignore writes, and decode as 0. Status bits are not affected by route_en_i.
- R9: Any other offset reads zero and ignores writes. This includes the n = 0 and n = 3 slots and offsets that are not word-aligned.
- R10: Reset clears every stored bit, so every interrupt reports 2'b00.
- R11: A write takes effect at the rising clock edge on which req_valid_i and req_write_i are high. rd_data_o and grp_o follow the stored state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_secure_i | input | 1 | Access is secure |
| req_addr_i | input | 12 | Byte offset within the frame |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, combinational, zero when no read is active |
| sec_disable_i | input | 1 | 1 = security gating disabled |
| route_en_i | input | 1 | Affinity routing enabled |
| impl_mask_i | input | 64 | Implemented-interrupt mask, bit k = interrupt 1056 + k |
| grp_o | output | 128 | 2-bit group class per interrupt |

## Verification
The hardest situation to reach from the ports is stored state that is hidden by one rule and then exposed again. For example, a modifier bit is written while routing is on. Routing is then turned off, or the interrupt's mask bit is cleared, and a write arrives that must not touch the bit.

To reach this, the bench cycles through every combination of security-disable, access attribute, routing and two mask patterns, without resetting between combinations. Earlier writes therefore stay stored while later configurations mask them. An arithmetic model of the raw storage predicts every read and every class output.

A final sweep writes ones across all mapped offsets and then zeros across every unmapped offset, to confirm that the unmapped writes leave no trace.

// File: rtl/irq_grpmod_pkg.sv
package irq_grpmod_pkg;

  typedef enum logic [1:0] {
    GRP_G0_SEC  = 2'b00,
    GRP_G1_NSEC = 2'b01,
    GRP_G1_SEC  = 2'b10
  } grp_e;

  // {modifier, status} -> legal group; the reserved pair folds to non-secure group 1
  function automatic grp_e grp_decode(input logic mod_b, input logic stat_b);
    case ({mod_b, stat_b})
      2'b00:   return GRP_G0_SEC;
      2'b10:   return GRP_G1_SEC;
      default: return GRP_G1_NSEC;
    endcase
  endfunction

endpackage

// File: rtl/irq_grpmod_addr_dec.sv
module irq_grpmod_addr_dec #(
  parameter int unsigned          ADDR_W    = 12,
  parameter int unsigned          NUM_REGS  = 2,
  parameter int unsigned          FIRST_IDX = 1,
  parameter logic [ADDR_W-1:0]    BASE      = 12'hD00
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o,
  output logic                hit_o
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_cmp
    localparam logic [ADDR_W-1:0] OFFS = BASE + ADDR_W'(4 * (FIRST_IDX + r));
    assign sel_o[r] = (addr_i == OFFS);
  end

  assign hit_o = |sel_o;

endmodule

// File: rtl/irq_grpmod_bitbank.sv
module irq_grpmod_bitbank #(
  parameter int unsigned NUM_REGS = 2,
  parameter int unsigned REG_W    = 32,
  localparam int unsigned TOT_W   = NUM_REGS * REG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [NUM_REGS-1:0] wr_sel_i,
  input  logic [REG_W-1:0]    wdata_i,
  input  logic [TOT_W-1:0]    wmask_i,
  output logic [TOT_W-1:0]    q_o
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [REG_W-1:0] m;
    assign m = wmask_i[r*REG_W +: REG_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   q_o[r*REG_W +: REG_W] <= '0;
      else if (wr_en_i && wr_sel_i[r])
        q_o[r*REG_W +: REG_W] <= (q_o[r*REG_W +: REG_W] & ~m) | (wdata_i & m);
    end
  end

  // masked bits never change on a write
  assert_masked_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((q_o ^ $past(q_o)) & ~$past(wmask_i)) == '0);

  // without a write strobe nothing moves
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(q_o));

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_clear_R10: assert (q_o == '0);

endmodule

// File: rtl/irq_grpmod_classify.sv
module irq_grpmod_classify
  import irq_grpmod_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IRQ-1:0]   mod_i,
  input  logic [NUM_IRQ-1:0]   stat_i,
  output logic [2*NUM_IRQ-1:0] grp_o
);

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    assign grp_o[2*k +: 2] = grp_decode(mod_i[k], stat_i[k]);

    assert_no_reserved_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_o[2*k +: 2] != 2'b11);
  end

endmodule

// File: rtl/irq_grpmod_bank.sv
module irq_grpmod_bank
  import irq_grpmod_pkg::*;
#(
  parameter int unsigned       REG_W     = 32,
  parameter int unsigned       NUM_REGS  = 2,
  parameter int unsigned       FIRST_IDX = 1,
  parameter int unsigned       ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] MOD_BASE  = 12'hD00,
  parameter logic [ADDR_W-1:0] STAT_BASE = 12'hC80,
  localparam int unsigned      NUM_IRQ   = REG_W * NUM_REGS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic                 req_secure_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [REG_W-1:0]     req_wdata_i,
  output logic [REG_W-1:0]     rd_data_o,
  input  logic                 sec_disable_i,
  input  logic                 route_en_i,
  input  logic [NUM_IRQ-1:0]   impl_mask_i,
  output logic [2*NUM_IRQ-1:0] grp_o
);

  logic [NUM_REGS-1:0] mod_sel, stat_sel;
  logic                mod_hit, stat_hit;
  logic                access_ok, wr_en, rd_en;
  logic [NUM_IRQ-1:0]  mod_mask, stat_mask, mod_q, stat_q, mod_eff, stat_eff;

  irq_grpmod_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .FIRST_IDX(FIRST_IDX), .BASE(MOD_BASE)
  ) u_mod_dec (
    .addr_i(req_addr_i), .sel_o(mod_sel), .hit_o(mod_hit)
  );

  irq_grpmod_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .FIRST_IDX(FIRST_IDX), .BASE(STAT_BASE)
  ) u_stat_dec (
    .addr_i(req_addr_i), .sel_o(stat_sel), .hit_o(stat_hit)
  );

  assign access_ok = sec_disable_i | req_secure_i;
  assign wr_en     = req_valid_i & req_write_i & access_ok;
  assign rd_en     = req_valid_i & ~req_write_i & access_ok;

  // modifier is reserved-zero when routing is off
  assign mod_mask  = impl_mask_i & {NUM_IRQ{route_en_i}};
  assign stat_mask = impl_mask_i;

  irq_grpmod_bitbank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_mod_bank (
    .clk_i, .rst_ni,
    .wr_en_i (wr_en & mod_hit),
    .wr_sel_i(mod_sel),
    .wdata_i (req_wdata_i),
    .wmask_i (mod_mask),
    .q_o     (mod_q)
  );

  irq_grpmod_bitbank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_stat_bank (
    .clk_i, .rst_ni,
    .wr_en_i (wr_en & stat_hit),
    .wr_sel_i(stat_sel),
    .wdata_i (req_wdata_i),
    .wmask_i (stat_mask),
    .q_o     (stat_q)
  );

  assign mod_eff  = mod_q & mod_mask;
  assign stat_eff = stat_q & stat_mask;

  always_comb begin
    rd_data_o = '0;
    if (rd_en) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (mod_sel[r])  rd_data_o = rd_data_o | mod_eff[r*REG_W +: REG_W];
        if (stat_sel[r]) rd_data_o = rd_data_o | stat_eff[r*REG_W +: REG_W];
      end
    end
  end

  irq_grpmod_classify #(.NUM_IRQ(NUM_IRQ)) u_classify (
    .clk_i, .rst_ni,
    .mod_i (mod_eff),
    .stat_i(stat_eff),
    .grp_o (grp_o)
  );

  assert_ns_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !req_secure_i && !sec_disable_i)
      |=> $stable(mod_q) && $stable(stat_q));

  assert_ns_read_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && !req_secure_i && !sec_disable_i) |-> rd_data_o == '0);

  assert_unmapped_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !mod_hit && !stat_hit)
      |=> $stable(mod_q) && $stable(stat_q));

  assert_unmapped_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_hit && !stat_hit) |-> rd_data_o == '0);

  assert_route_off_mod_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !route_en_i) |=> $stable(mod_q));

  assert_exclusive_decode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mod_sel, stat_sel}));

endmodule

// File: tb/irq_grpmod_bank_tb_top.sv
`timescale 1ns/1ps
module irq_grpmod_bank_tb_top;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0, req_write_i = 1'b0, req_secure_i = 1'b0;
  logic [11:0]  req_addr_i = '0;
  logic [31:0]  req_wdata_i = '0;
  logic [31:0]  rd_data_o;
  logic         sec_disable_i = 1'b0, route_en_i = 1'b0;
  logic [63:0]  impl_mask_i = '1;
  logic [127:0] grp_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench copy of raw storage
  logic [63:0] mod_s = '0, stat_s = '0;

  always #5 clk_i = ~clk_i;

  irq_grpmod_bank dut_i (.*);

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int mod_idx(input logic [11:0] a);
    if (a == 12'hD04) return 0;
    if (a == 12'hD08) return 1;
    return -1;
  endfunction

  function automatic int stat_idx(input logic [11:0] a);
    if (a == 12'hC84) return 0;
    if (a == 12'hC88) return 1;
    return -1;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a, input logic sec);
    logic [63:0] me, se;
    me = mod_s & impl_mask_i & {64{route_en_i}};
    se = stat_s & impl_mask_i;
    if (!(sec_disable_i || sec)) return '0;
    if (mod_idx(a) >= 0)  return me[32*mod_idx(a) +: 32];
    if (stat_idx(a) >= 0) return se[32*stat_idx(a) +: 32];
    return '0;
  endfunction

  function automatic logic [1:0] exp_grp(input int k);
    logic me, se;
    me = mod_s[k] & impl_mask_i[k] & route_en_i;
    se = stat_s[k] & impl_mask_i[k];
    if (me && se) return 2'b01;
    return {me, se};
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d, input logic sec);
    logic [31:0] m;
    if (!(sec_disable_i || sec)) return;
    if (mod_idx(a) >= 0) begin
      m = impl_mask_i[32*mod_idx(a) +: 32] & {32{route_en_i}};
      mod_s[32*mod_idx(a) +: 32] = (mod_s[32*mod_idx(a) +: 32] & ~m) | (d & m);
    end
    if (stat_idx(a) >= 0) begin
      m = impl_mask_i[32*stat_idx(a) +: 32];
      stat_s[32*stat_idx(a) +: 32] = (stat_s[32*stat_idx(a) +: 32] & ~m) | (d & m);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic sec);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d; req_secure_i = sec;
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0;
    model_write(a, d, sec);
  endtask

  task automatic do_read(input string req, input logic [11:0] a, input logic sec);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 0; req_addr_i = a; req_secure_i = sec;
    #1;
    check(req, $sformatf("read %h sec=%0d", a, sec), rd_data_o, exp_read(a, sec));
    req_valid_i = 0;
  endtask

  task automatic check_groups(input string req);
    #1;
    for (int k = 0; k < 64; k++)
      check(req, $sformatf("grp irq %0d", 1056 + k), {30'd0, grp_o[2*k +: 2]}, {30'd0, exp_grp(k)});
  endtask

  localparam logic [11:0] MAPPED [4] = '{12'hD04, 12'hD08, 12'hC84, 12'hC88};

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state
    sec_disable_i = 1; route_en_i = 1;
    check_groups("R10");
    for (int i = 0; i < 4; i++) do_read("R10", MAPPED[i], 1'b1);
    rst_ni = 1;

    // R3 R4: all four pairs, secure writes with gating disabled
    do_write(12'hD04, 32'h0000_000C, 1'b1);
    do_write(12'hC84, 32'h0000_000A, 1'b1);
    check_groups("R3");
    // k=1: {0,1}, k=2: {1,0}, k=3: {1,1}
    check("R3", "irq 1057", {30'd0, grp_o[3:2]}, 32'd1);
    check("R3", "irq 1058", {30'd0, grp_o[5:4]}, 32'd2);
    check("R4", "irq 1059 reserved", {30'd0, grp_o[7:6]}, 32'd1);

    // R11: no change before the commit edge, change right after it
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 1; req_addr_i = 12'hD08; req_wdata_i = 32'h1; req_secure_i = 1;
    #1;
    check("R11", "pre-edge grp irq 1088", {30'd0, grp_o[65:64]}, 32'd0);
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0;
    model_write(12'hD08, 32'h1, 1'b1);
    #1;
    check("R11", "post-edge grp irq 1088", {30'd0, grp_o[65:64]}, 32'd2);

    // R5 R6 R7 R8: sweep configurations without reset
    for (int cfg = 0; cfg < 16; cfg++) begin
      sec_disable_i = cfg[0];
      route_en_i    = cfg[2];
      impl_mask_i   = cfg[3] ? 64'hF0F0_5A5A_0FF0_A5C3 : '1;
      for (int i = 0; i < 4; i++)
        do_write(MAPPED[i], 32'h9E37_79B9 * (cfg * 4 + i + 1), cfg[1]);
      check_groups(cfg[2] ? "R7" : "R8");
      for (int i = 0; i < 4; i++) begin
        do_read(cfg[0] ? "R6" : "R5", MAPPED[i], 1'b0);
        do_read(cfg[3] ? "R7" : "R6", MAPPED[i], 1'b1);
      end
    end

    // R9: unmapped offsets
    sec_disable_i = 1; route_en_i = 1; impl_mask_i = '1;
    for (int i = 0; i < 4; i++) do_write(MAPPED[i], 32'hFFFF_FFFF, 1'b1);
    for (int a = 12'hC7C; a <= 12'hD10; a++) begin
      if (mod_idx(12'(a)) < 0 && stat_idx(12'(a)) < 0) begin
        do_write(12'(a), 32'h0, 1'b1);
        do_read("R9", 12'(a), 1'b1);
      end
    end
    for (int i = 0; i < 4; i++) do_read("R9", MAPPED[i], 1'b1);
    check_groups("R4");
    check_groups("R9");

    // R1 R2: single-bit placement
    for (int i = 0; i < 4; i++) do_write(MAPPED[i], 32'h0, 1'b1);
    do_write(12'hD08, 32'h8000_0000, 1'b1);
    check("R1", "irq 1119 modifier", {30'd0, grp_o[127:126]}, 32'd2);
    do_write(12'hC84, 32'h0000_0001, 1'b1);
    check("R2", "irq 1056 status", {30'd0, grp_o[1:0]}, 32'd1);
    check_groups("R1");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule